// File: doc/BRIEF.md
# Banked UART Register File

This block is the host-facing register file of a UART-style peripheral. A host reaches it over a simple synchronous bus with a 3-bit address, separate write and read enables, and 8-bit data in each direction. Eight addresses are not enough for every register, so several banks share the same address space. The live value of the line control register decides which bank the host sees. The line control register stays at address 3 in every bank, so software can always switch to another bank.

There are three banks. The general bank holds the data port, interrupt enable, FIFO control, modem control and an optional trigger-level pair. The divisor bank holds the two bytes of the baud divisor. The enhanced bank opens only for one exact line control value, and holds the enhanced feature register and four flow-control characters. Some control bits stay locked until software sets the enhanced-functions enable.

The block drives the decoded register values to a UART core as plain outputs. It also raises strobes toward the FIFOs. After a FIFO reset command it holds a short settle window, and during that window data-port accesses do not take effect.

Top module: `uart_regbank`

## Requirements
- R1: After reset every register reads 0x00, except the divisor, which is 0x0001. Both busy flags are low.
- R2: Address 3 always reads and writes the line control register, whatever bank is selected.
- R3: When line control bit 7 is 0, the general bank is visible:
  - address 0 is the data port;
  - address 1 is interrupt enable;
  - address 2 is FIFO control, write-only, reads 0x00;
  - address 4 is modem control.

  A read at address 0 returns rx_data_i and pulses rhr_pop_o. A write at address 0 pulses thr_push_o with the written byte.
- R4: When line control bit 7 is 1 and the register is not 0xBF, address 0 is the divisor low byte and address 1 is the divisor high byte. Every other address except 3 reads 0x00 and ignores writes.
- R5: When line control is exactly 0xBF, the enhanced bank is visible:
  - address 2 is the enhanced feature register;
  - addresses 4 and 5 are the first and second XON characters;
  - addresses 6 and 7 are the first and second XOFF characters.

  Addresses 0 and 1 read 0x00. The flow-control characters and the enhanced feature register change only in this bank.
- R6: Enhanced feature bit 7 drives auto_cts_en_o, bit 6 auto_rts_en_o, bit 5 spec_char_en_o and bit 4 enh_en_o. Bits 3:0 drive sw_flow_mode_o.
- R7: While enh_en_o is 0, writes leave these bits unchanged: interrupt enable bits 7:4, modem control bits 7:5 and 2, and FIFO control bits 5:4.
- R8: When enh_en_o is 1 and modem control bit 2 is 1, general addresses 6 and 7 are the high and low trigger registers. Otherwise those addresses read 0x00 and ignore writes.
- R9: A FIFO control write pulses rx_fifo_rst_o in that cycle when data bit 1 is set, and tx_fifo_rst_o when bit 2 is set. The register keeps only bits 7:4 and 0.
- R10: After a FIFO reset strobe, the matching busy flag is high for the next SETTLE_CYC cycles. While rx_busy_o is high, data-port reads return 0x00 with no pop. While tx_busy_o is high, data-port writes make no push.
- R11: Reserved bits read 0 whatever was written: modem control bit 3 and FIFO control bits 3:1.
- R12: A read of an address not mapped in the current bank returns 0x00 and changes no state. General address 5 is one such address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write enable |
| rd_en_i | input | 1 | Read enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| rx_data_i | input | 8 | Head byte of the receive FIFO |
| rhr_pop_o | output | 1 | Receive FIFO pop strobe |
| thr_push_o | output | 1 | Transmit FIFO push strobe |
| thr_data_o | output | 8 | Byte to push |
| rx_fifo_rst_o | output | 1 | Receive FIFO reset strobe |
| tx_fifo_rst_o | output | 1 | Transmit FIFO reset strobe |
| rx_busy_o | output | 1 | Receive settle window active |
| tx_busy_o | output | 1 | Transmit settle window active |
| line_ctl_o | output | 8 | Line control register |
| divisor_o | output | 16 | Baud divisor |
| int_en_o | output | 8 | Interrupt enable register |
| fifo_ctl_o | output | 8 | Stored FIFO control bits |
| mdm_ctl_o | output | 8 | Modem control register |
| auto_cts_en_o | output | 1 | Enhanced feature bit 7 |
| auto_rts_en_o | output | 1 | Enhanced feature bit 6 |
| spec_char_en_o | output | 1 | Enhanced feature bit 5 |
| enh_en_o | output | 1 | Enhanced feature bit 4 |
| sw_flow_mode_o | output | 4 | Enhanced feature bits 3:0 |
| xon1_o | output | 8 | First XON character |
| xon2_o | output | 8 | Second XON character |
| xoff1_o | output | 8 | First XOFF character |
| xoff2_o | output | 8 | Second XOFF character |
| trig_hi_o | output | 8 | High trigger level |
| trig_lo_o | output | 8 | Low trigger level |

## Verification
The assertions check these rules on every cycle:
- the lock on protected bits while enh_en_o is clear;
- the reserved bits staying zero;
- the divisor and enhanced registers staying unchanged outside their banks;
- FIFO control staying unchanged outside the general bank;
- each FIFO reset strobe raising its busy flag;
- no pop or push while a busy flag is high.

Only the bench scenarios can show the address decoding that each line control value produces, including the 0xBE and 0xBF boundary. They also show the exact read-back values after masked writes, the bit placement of the enhanced feature outputs, and the precise length of the settle window.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

    localparam logic [7:0] ENH_KEY       = 8'hBF;
    localparam logic [7:0] INT_EN_PROT   = 8'hF0;
    localparam logic [7:0] MDM_PROT      = 8'hE4;
    localparam logic [7:0] MDM_RSVD      = 8'h08;
    localparam logic [7:0] FIFO_PROT     = 8'h30;
    localparam logic [7:0] FIFO_KEEP     = 8'hF1;
    localparam int         MDM_TRIG_BIT  = 2;
    localparam int         ENH_EN_BIT    = 4;
    localparam int         RX_RST_BIT    = 1;
    localparam int         TX_RST_BIT    = 2;

    typedef enum logic [1:0] {
        BANK_GEN,
        BANK_DIV,
        BANK_ENH
    } bank_e;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_INT_EN,
        SEL_FIFO_CTL,
        SEL_LINE,
        SEL_MDM,
        SEL_TRIG_HI,
        SEL_TRIG_LO,
        SEL_DIV_LO,
        SEL_DIV_HI,
        SEL_ENH,
        SEL_XON1,
        SEL_XON2,
        SEL_XOFF1,
        SEL_XOFF2
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] line_ctl;
        logic [7:0] div_lo;
        logic [7:0] div_hi;
        logic [7:0] int_en;
        logic [7:0] fifo_ctl;
        logic [7:0] mdm_ctl;
        logic [7:0] enh_feat;
        logic [7:0] xon1;
        logic [7:0] xon2;
        logic [7:0] xoff1;
        logic [7:0] xoff2;
        logic [7:0] trig_hi;
        logic [7:0] trig_lo;
    } regs_t;

    // Merge a write into a register: locked bits keep old value, reserved bits forced low.
    function automatic logic [7:0] guarded_write(
        input logic [7:0] old_val,
        input logic [7:0] new_val,
        input logic [7:0] prot_mask,
        input logic [7:0] zero_mask,
        input logic       unlocked
    );
        logic [7:0] hold;
        hold = unlocked ? 8'h00 : prot_mask;
        return ((old_val & hold) | (new_val & ~hold)) & ~zero_mask;
    endfunction

endpackage

// File: rtl/uart_bank_decode.sv
module uart_bank_decode
    import uart_regbank_pkg::*;
#(
    parameter bit HAS_TRIG = 1'b1
) (
    input  logic [7:0] line_ctl,
    input  logic       enh_en,
    input  logic       trig_gate,
    input  logic [2:0] addr,
    output bank_e      bank,
    output reg_sel_e   sel
);

    always_comb begin
        if (line_ctl == ENH_KEY)   bank = BANK_ENH;
        else if (line_ctl[7])      bank = BANK_DIV;
        else                       bank = BANK_GEN;
    end

    always_comb begin
        sel = SEL_NONE;
        if (addr == 3'd3) begin
            sel = SEL_LINE;
        end else begin
            unique case (bank)
                BANK_GEN: begin
                    case (addr)
                        3'd0: sel = SEL_DATA;
                        3'd1: sel = SEL_INT_EN;
                        3'd2: sel = SEL_FIFO_CTL;
                        3'd4: sel = SEL_MDM;
                        3'd6: sel = (HAS_TRIG && enh_en && trig_gate) ? SEL_TRIG_HI : SEL_NONE;
                        3'd7: sel = (HAS_TRIG && enh_en && trig_gate) ? SEL_TRIG_LO : SEL_NONE;
                        default: sel = SEL_NONE;
                    endcase
                end
                BANK_DIV: begin
                    case (addr)
                        3'd0: sel = SEL_DIV_LO;
                        3'd1: sel = SEL_DIV_HI;
                        default: sel = SEL_NONE;
                    endcase
                end
                BANK_ENH: begin
                    case (addr)
                        3'd2: sel = SEL_ENH;
                        3'd4: sel = SEL_XON1;
                        3'd5: sel = SEL_XON2;
                        3'd6: sel = SEL_XOFF1;
                        3'd7: sel = SEL_XOFF2;
                        default: sel = SEL_NONE;
                    endcase
                end
                default: sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/uart_settle_timer.sv
module uart_settle_timer #(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);

    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)             cnt_d = LOAD;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_regbank_pkg::*;
#(
    parameter bit HAS_TRIG   = 1'b1,
    parameter int SETTLE_CYC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  addr_i,
    input  logic        wr_en_i,
    input  logic        rd_en_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    input  logic [7:0]  rx_data_i,
    output logic        rhr_pop_o,
    output logic        thr_push_o,
    output logic [7:0]  thr_data_o,
    output logic        rx_fifo_rst_o,
    output logic        tx_fifo_rst_o,
    output logic        rx_busy_o,
    output logic        tx_busy_o,
    output logic [7:0]  line_ctl_o,
    output logic [15:0] divisor_o,
    output logic [7:0]  int_en_o,
    output logic [7:0]  fifo_ctl_o,
    output logic [7:0]  mdm_ctl_o,
    output logic        auto_cts_en_o,
    output logic        auto_rts_en_o,
    output logic        spec_char_en_o,
    output logic        enh_en_o,
    output logic [3:0]  sw_flow_mode_o,
    output logic [7:0]  xon1_o,
    output logic [7:0]  xon2_o,
    output logic [7:0]  xoff1_o,
    output logic [7:0]  xoff2_o,
    output logic [7:0]  trig_hi_o,
    output logic [7:0]  trig_lo_o
);

    localparam regs_t RESET_REGS = '{
        line_ctl: 8'h00, div_lo: 8'h01, div_hi: 8'h00, int_en: 8'h00,
        fifo_ctl: 8'h00, mdm_ctl: 8'h00, enh_feat: 8'h00, xon1: 8'h00,
        xon2: 8'h00, xoff1: 8'h00, xoff2: 8'h00, trig_hi: 8'h00, trig_lo: 8'h00
    };

    regs_t    r_d, r_q;
    bank_e    bank;
    reg_sel_e sel;
    logic     unlocked;
    logic     wr_fifo;
    logic [1:0] rst_strobe;
    logic [1:0] busy;

    assign unlocked = r_q.enh_feat[ENH_EN_BIT];

    uart_bank_decode #(
        .HAS_TRIG (HAS_TRIG)
    ) u_dec (
        .line_ctl  (r_q.line_ctl),
        .enh_en    (unlocked),
        .trig_gate (r_q.mdm_ctl[MDM_TRIG_BIT]),
        .addr      (addr_i),
        .bank      (bank),
        .sel       (sel)
    );

    // One settle timer per FIFO direction: index 0 receive, index 1 transmit.
    assign wr_fifo       = wr_en_i && (sel == SEL_FIFO_CTL);
    assign rst_strobe[0] = wr_fifo && wdata_i[RX_RST_BIT];
    assign rst_strobe[1] = wr_fifo && wdata_i[TX_RST_BIT];

    for (genvar g = 0; g < 2; g++) begin : g_settle
        uart_settle_timer #(
            .SETTLE_CYC (SETTLE_CYC)
        ) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (rst_strobe[g]),
            .busy  (busy[g])
        );
    end

    // Next-state computation for every register.
    always_comb begin
        r_d = r_q;
        if (wr_en_i) begin
            unique case (sel)
                SEL_LINE:     r_d.line_ctl = wdata_i;
                SEL_DIV_LO:   r_d.div_lo   = wdata_i;
                SEL_DIV_HI:   r_d.div_hi   = wdata_i;
                SEL_INT_EN:   r_d.int_en   = guarded_write(r_q.int_en, wdata_i,
                                                           INT_EN_PROT, 8'h00, unlocked);
                SEL_MDM:      r_d.mdm_ctl  = guarded_write(r_q.mdm_ctl, wdata_i,
                                                           MDM_PROT, MDM_RSVD, unlocked);
                SEL_FIFO_CTL: r_d.fifo_ctl = guarded_write(r_q.fifo_ctl, wdata_i,
                                                           FIFO_PROT, ~FIFO_KEEP, unlocked);
                SEL_ENH:      r_d.enh_feat = wdata_i;
                SEL_XON1:     r_d.xon1     = wdata_i;
                SEL_XON2:     r_d.xon2     = wdata_i;
                SEL_XOFF1:    r_d.xoff1    = wdata_i;
                SEL_XOFF2:    r_d.xoff2    = wdata_i;
                SEL_TRIG_HI:  r_d.trig_hi  = wdata_i;
                SEL_TRIG_LO:  r_d.trig_lo  = wdata_i;
                default:      r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_REGS;
        else        r_q <= r_d;
    end

    // Read mux: unmapped and write-only addresses return zero.
    always_comb begin
        unique case (sel)
            SEL_DATA:    rdata_o = busy[0] ? 8'h00 : rx_data_i;
            SEL_LINE:    rdata_o = r_q.line_ctl;
            SEL_DIV_LO:  rdata_o = r_q.div_lo;
            SEL_DIV_HI:  rdata_o = r_q.div_hi;
            SEL_INT_EN:  rdata_o = r_q.int_en;
            SEL_MDM:     rdata_o = r_q.mdm_ctl;
            SEL_ENH:     rdata_o = r_q.enh_feat;
            SEL_XON1:    rdata_o = r_q.xon1;
            SEL_XON2:    rdata_o = r_q.xon2;
            SEL_XOFF1:   rdata_o = r_q.xoff1;
            SEL_XOFF2:   rdata_o = r_q.xoff2;
            SEL_TRIG_HI: rdata_o = r_q.trig_hi;
            SEL_TRIG_LO: rdata_o = r_q.trig_lo;
            default:     rdata_o = 8'h00;
        endcase
    end

    assign rhr_pop_o      = rd_en_i && (sel == SEL_DATA) && !busy[0];
    assign thr_push_o     = wr_en_i && (sel == SEL_DATA) && !busy[1];
    assign thr_data_o     = wdata_i;
    assign rx_fifo_rst_o  = rst_strobe[0];
    assign tx_fifo_rst_o  = rst_strobe[1];
    assign rx_busy_o      = busy[0];
    assign tx_busy_o      = busy[1];

    assign line_ctl_o     = r_q.line_ctl;
    assign divisor_o      = {r_q.div_hi, r_q.div_lo};
    assign int_en_o       = r_q.int_en;
    assign fifo_ctl_o     = r_q.fifo_ctl;
    assign mdm_ctl_o      = r_q.mdm_ctl;
    assign auto_cts_en_o  = r_q.enh_feat[7];
    assign auto_rts_en_o  = r_q.enh_feat[6];
    assign spec_char_en_o = r_q.enh_feat[5];
    assign enh_en_o       = r_q.enh_feat[4];
    assign sw_flow_mode_o = r_q.enh_feat[3:0];
    assign xon1_o         = r_q.xon1;
    assign xon2_o         = r_q.xon2;
    assign xoff1_o        = r_q.xoff1;
    assign xoff2_o        = r_q.xoff2;
    assign trig_hi_o      = r_q.trig_hi;
    assign trig_lo_o      = r_q.trig_lo;

    // Bank state is reflected by line_ctl_o; kept for debug visibility of the decode.
    logic bank_is_enh;
    assign bank_is_enh = (bank == BANK_ENH);

endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rhr_pop_o,
    input logic        thr_push_o,
    input logic        rx_fifo_rst_o,
    input logic        tx_fifo_rst_o,
    input logic        rx_busy_o,
    input logic        tx_busy_o,
    input logic [7:0]  line_ctl_o,
    input logic [15:0] divisor_o,
    input logic [7:0]  int_en_o,
    input logic [7:0]  fifo_ctl_o,
    input logic [7:0]  mdm_ctl_o,
    input logic        auto_cts_en_o,
    input logic        auto_rts_en_o,
    input logic        spec_char_en_o,
    input logic        enh_en_o,
    input logic [3:0]  sw_flow_mode_o,
    input logic [7:0]  xon1_o,
    input logic [7:0]  xon2_o,
    input logic [7:0]  xoff1_o,
    input logic [7:0]  xoff2_o
);

    assert_div_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !line_ctl_o[7] |=> $stable(divisor_o));

    assert_enh_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ctl_o != 8'hBF) |=> $stable({auto_cts_en_o, auto_rts_en_o, spec_char_en_o,
                                            enh_en_o, sw_flow_mode_o,
                                            xon1_o, xon2_o, xoff1_o, xoff2_o}));

    assert_lock_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_en_o |=> ($stable(int_en_o[7:4]) && $stable(mdm_ctl_o[7:5])
                       && $stable(mdm_ctl_o[2]) && $stable(fifo_ctl_o[5:4])));

    assert_fifo_ctl_general_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_ctl_o[7] |=> $stable(fifo_ctl_o));

    assert_rx_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_rst_o |=> rx_busy_o);

    assert_tx_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_rst_o |=> tx_busy_o);

    assert_no_pop_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_busy_o |-> !rhr_pop_o);

    assert_no_push_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy_o |-> !thr_push_o);

    assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mdm_ctl_o[3] == 1'b0) && (fifo_ctl_o[3:1] == 3'b000));

endmodule

bind uart_regbank uart_regbank_chk u_chk (.*);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;

    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic [7:0]  rx_data_i = 8'hA5;
    logic        rhr_pop_o, thr_push_o;
    logic [7:0]  thr_data_o;
    logic        rx_fifo_rst_o, tx_fifo_rst_o, rx_busy_o, tx_busy_o;
    logic [7:0]  line_ctl_o, int_en_o, fifo_ctl_o, mdm_ctl_o;
    logic [15:0] divisor_o;
    logic        auto_cts_en_o, auto_rts_en_o, spec_char_en_o, enh_en_o;
    logic [3:0]  sw_flow_mode_o;
    logic [7:0]  xon1_o, xon2_o, xoff1_o, xoff2_o, trig_hi_o, trig_lo_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;
    rd_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_regbank u0 (.*);

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data against the scoreboard queue mid-cycle.
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (rd_en_i && exp_q.size() > 0) begin
            rd_item_t it;
            it = exp_q.pop_front();
            check(it.tag, {8'h00, rdata_o}, {8'h00, it.exp});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        exp_q.push_back('{exp: e, tag: tag});
        addr_i = a; rd_en_i = 1'b1;
        #(CLK_PERIOD/2);
        rd_en_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 line_ctl", {8'h00, line_ctl_o}, 16'h0000);
        check("R1 divisor", divisor_o, 16'h0001);
        check("R1 busy", {14'h0, rx_busy_o, tx_busy_o}, 16'h0000);
        rd(3'd3, 8'h00, "R1 read line_ctl");

        // General bank, locked bits
        wr(3'd3, 8'h03);
        rd(3'd3, 8'h03, "R2 line_ctl general");
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'h0F, "R7 int_en locked");
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'h13, "R7 R11 mdm_ctl locked");
        wr(3'd6, 8'h55);
        rd(3'd6, 8'h00, "R8 trig hidden");
        rd(3'd5, 8'h00, "R12 unmapped read");
        rd(3'd2, 8'h00, "R3 fifo_ctl write-only");

        // Data port
        @(negedge clk);
        addr_i = 3'd0; rd_en_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R3 data read", {8'h00, rdata_o}, 16'h00A5);
        check("R3 pop", {15'h0, rhr_pop_o}, 16'h0001);
        @(negedge clk);
        rd_en_i = 1'b0; addr_i = 3'd0; wdata_i = 8'h3C; wr_en_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R3 push", {7'h0, thr_push_o, thr_data_o}, 16'h013C);
        @(negedge clk);
        wr_en_i = 1'b0;

        // Divisor bank
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        check("R4 divisor out", divisor_o, 16'h1234);
        rd(3'd1, 8'h12, "R4 div hi");
        rd(3'd2, 8'h00, "R4 unmapped");
        rd(3'd3, 8'h80, "R2 line_ctl divisor bank");
        wr(3'd3, 8'hBE);
        rd(3'd0, 8'h34, "R4 0xBE div lo");

        // Enhanced bank
        wr(3'd3, 8'hBF);
        rd(3'd0, 8'h00, "R5 addr0 unmapped");
        wr(3'd2, 8'hDA);
        wr(3'd4, 8'h11);
        wr(3'd5, 8'h13);
        wr(3'd6, 8'h91);
        wr(3'd7, 8'h93);
        rd(3'd2, 8'hDA, "R5 enh_feat");
        rd(3'd4, 8'h11, "R5 xon1");
        rd(3'd5, 8'h13, "R5 xon2");
        rd(3'd6, 8'h91, "R5 xoff1");
        rd(3'd7, 8'h93, "R5 xoff2");
        check("R6 feature bits",
              {8'h00, auto_cts_en_o, auto_rts_en_o, spec_char_en_o, enh_en_o, sw_flow_mode_o},
              16'h00DA);
        check("R5 divisor untouched", divisor_o, 16'h1234);

        // General bank, unlocked
        wr(3'd3, 8'h03);
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'hFF, "R7 int_en unlocked");
        wr(3'd4, 8'hFF);
        rd(3'd4, 8'hF7, "R11 mdm_ctl reserved bit");
        wr(3'd6, 8'h5A);
        wr(3'd7, 8'hC3);
        rd(3'd6, 8'h5A, "R8 trig hi");
        rd(3'd7, 8'hC3, "R8 trig lo");

        // FIFO reset and settle window
        @(negedge clk);
        addr_i = 3'd2; wdata_i = 8'hF7; wr_en_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R9 reset strobes", {14'h0, rx_fifo_rst_o, tx_fifo_rst_o}, 16'h0003);
        @(negedge clk);
        wr_en_i = 1'b0; addr_i = 3'd0; rd_en_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R9 fifo_ctl stored", {8'h00, fifo_ctl_o}, 16'h00F1);
        check("R10 busy cycle1 read", {7'h0, rhr_pop_o, rdata_o}, 16'h0000);
        @(negedge clk);
        rd_en_i = 1'b0; wdata_i = 8'h77; wr_en_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R10 busy cycle2 push", {14'h0, tx_busy_o, thr_push_o}, 16'h0002);
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b1;
        #(CLK_PERIOD/4);
        check("R10 after window", {6'h0, rx_busy_o, rhr_pop_o, rdata_o}, 16'h01A5);
        @(negedge clk);
        rd_en_i = 1'b0;

        // Relock and confirm held bits
        wr(3'd3, 8'hBF);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'h03);
        wr(3'd4, 8'h00);
        rd(3'd4, 8'hE4, "R7 mdm_ctl relocked");
        rd(3'd6, 8'h00, "R8 trig hidden when locked");
        wr(3'd2, 8'h00);
        check("R7 fifo_ctl held bits", {8'h00, fifo_ctl_o}, 16'h0030);

        repeat (3) @(negedge clk);
        check("R12 queue drained", 16'(exp_q.size()), 16'h0000);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule